// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date in seven packed-BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. An internal prescaler divides the system clock down to a one-second step. Each step ripples through the registers in the same clock cycle. Seconds carry into minutes, minutes into hours, hours into the day of week and the date, the date into the month, and the month into the year. The last date of each month is corrected automatically, and February gets a 29th day in leap years.

Hours run in one of two formats, chosen by a bit inside the hours register. In 24-hour format the register holds 00 to 23. In 12-hour format it holds 01 to 12 plus a PM flag. The top bit of the seconds register is a stop flag that freezes timekeeping. Reset leaves this flag set, so software must clear it as part of setting the time.

Software loads any register through a single-cycle write port, and reads any register through a registered read port. Bus decoding, the crystal oscillator and battery switching live outside this block.

Top module: `bcd_calendar_core`

## Requirements
- R1: Synchronous reset loads seconds 0x80 (stop flag set, 00 s), minutes 0x00, hours 0x00 (24-hour, midnight), day 0x01, date 0x01, month 0x01 and year 0x00. `rd_data` presents, one clock after sampling `rd_addr`, the register selected as it stood at that edge.
- R2: While seconds bit 7 is 1, no register changes except by a write.
- R3: While seconds bit 7 is 0, seconds advance one BCD step every `TICK_DIV` clocks. A write to seconds restarts the phase, so the first advance lands `TICK_DIV` clocks after the write edge.
- R4: Seconds and minutes count 00 to 59 in BCD (09 goes to 10). 59 wraps to 00 and carries into the next field.
- R5: With hours bit 6 = 0 (24-hour format), bits 5:0 count BCD 00 to 23. 23 wraps to 00 and carries into day and date.
- R6: With hours bit 6 = 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. 11 goes to 12 and toggles PM; 12 goes to 01. The day carry happens only on 11 PM to 12 AM.
- R7: The day of week (address 3) counts 1 to 7 once per day carry, wrapping from 7 to 1.
- R8: The date (address 4) wraps to 01 after 30 in April, June, September and November (BCD months 04, 06, 09, 11). It wraps after 31 in the other months, and after 28 or 29 in February (02). Each wrap carries into the month.
- R9: A year is a leap year when its two-digit BCD value is divisible by four, and 00 counts as a leap year.
- R10: The month (address 5) wraps from 12 to 01 and carries into the year. The year (address 6) wraps from 99 to 00.
- R11: A write to address 0 to 6 (seconds, minutes, hours, day, date, month, year) takes effect at the next edge. Unused bits are stored as 0: minutes bit 7, hours bit 7, day bits 7:3, date bits 7:6 and month bits 7:5. Writes to address 7 are ignored, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Packed-BCD write value |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 8 | Registered read value |

## Verification
A broken carry path shows up only at the moment a field wraps. A wrong month length or leap rule stays invisible until the date rolls over. The tests therefore preload each field to one step before its wrap and release the stop flag for exactly one second step, which puts the fault at the read port within `TICK_DIV` plus two clocks. A wrong prescaler phase moves the seconds change by a cycle, so the seconds value is sampled on both sides of the expected edge.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

  typedef enum logic [2:0] {
    RG_SEC  = 3'd0,
    RG_MIN  = 3'd1,
    RG_HOUR = 3'd2,
    RG_DOW  = 3'd3,
    RG_DATE = 3'd4,
    RG_MON  = 3'd5,
    RG_YEAR = 3'd6,
    RG_NONE = 3'd7
  } cal_reg_e;

  localparam int unsigned NUM_REGS = 7;

  // One packed-BCD increment of a two-digit value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // Bits kept on a write for each register.
  function automatic logic [7:0] keep_mask(input logic [2:0] a);
    case (a)
      RG_SEC:  return 8'hFF;
      RG_MIN:  return 8'h7F;
      RG_HOUR: return 8'h7F;
      RG_DOW:  return 8'h07;
      RG_DATE: return 8'h3F;
      RG_MON:  return 8'h1F;
      RG_YEAR: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bcdcal_prescaler.sv
module bcdcal_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> !tick); // R3

endmodule

// File: rtl/bcdcal_wrap_counter.sv
module bcdcal_wrap_counter #(
  parameter logic [7:0] LO = 8'h00
) (
  input  logic [7:0] cur,
  input  logic [7:0] top,
  input  logic       step,
  output logic [7:0] nxt,
  output logic       carry
);
  import bcdcal_pkg::*;

  logic at_top;
  assign at_top = (cur >= top);

  always_comb begin
    nxt   = cur;
    carry = 1'b0;
    if (step) begin
      if (at_top) begin
        nxt   = LO;
        carry = 1'b1;
      end else begin
        nxt = bcd_inc(cur);
      end
    end
  end
endmodule

// File: rtl/bcdcal_hour_step.sv
module bcdcal_hour_step (
  input  logic [7:0] cur,
  input  logic       step,
  output logic [7:0] nxt,
  output logic       carry
);
  import bcdcal_pkg::*;

  logic [7:0] inc24, inc12;
  assign inc24 = bcd_inc({2'b00, cur[5:0]});
  assign inc12 = bcd_inc({3'b000, cur[4:0]});

  always_comb begin
    nxt   = cur & 8'h7F;
    carry = 1'b0;
    if (step) begin
      if (!cur[6]) begin
        if (cur[5:0] >= 6'h23) begin
          nxt   = 8'h00;
          carry = 1'b1;
        end else begin
          nxt = inc24 & 8'h3F;
        end
      end else begin
        if (cur[4:0] >= 5'h12) begin
          nxt = 8'h40 | {2'b00, cur[5], 5'h01};
        end else if (cur[4:0] == 5'h11) begin
          nxt   = 8'h40 | {2'b00, ~cur[5], 5'h12};
          carry = cur[5];
        end else begin
          nxt = 8'h40 | {2'b00, cur[5], 5'h00} | (inc12 & 8'h1F);
        end
      end
    end
  end
endmodule

// File: rtl/bcdcal_month_len.sv
module bcdcal_month_len (
  input  logic [7:0] mon,
  input  logic       yr_tens_lsb,
  input  logic [3:0] yr_ones,
  output logic [7:0] last_date,
  output logic       leap
);
  logic [3:0] mod_sum;

  // 10*t + o is divisible by 4 exactly when 2*t[0] + o is.
  assign mod_sum = {2'b00, yr_tens_lsb, 1'b0} + yr_ones;
  assign leap    = (mod_sum[1:0] == 2'b00);

  always_comb begin
    case (mon)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned AW       = 3,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  import bcdcal_pkg::*;

  localparam int unsigned NR = NUM_REGS;

  logic [NR-1:0] wr_hit;
  logic [7:0]    wr_val;

  genvar gi;
  generate
    for (gi = 0; gi < NR; gi++) begin : g_hit
      assign wr_hit[gi] = wr_en && (wr_addr == AW'(gi));
    end
  endgenerate

  assign wr_val = wr_data & keep_mask(wr_addr);

  logic [7:0] r_sec, r_min, r_hour, r_dow, r_date, r_mon, r_year;

  // Prescaler
  logic tick;
  bcdcal_prescaler #(.DIV(TICK_DIV)) i_presc (
    .clk  (clk),
    .rst  (rst),
    .run  (!r_sec[7]),
    .clr  (wr_hit[RG_SEC]),
    .tick (tick)
  );

  // Carry chain
  logic [7:0] sec_nxt, min_nxt, hour_nxt, dow_nxt, date_nxt, mon_nxt, year_nxt;
  logic       sec_c, min_c, day_c, dow_c, date_c, mon_c, year_c;
  logic [7:0] mlen;
  logic       leap_yr;

  bcdcal_wrap_counter #(.LO(8'h00)) i_sec (
    .cur ({1'b0, r_sec[6:0]}), .top (8'h59), .step (tick),
    .nxt (sec_nxt), .carry (sec_c));

  bcdcal_wrap_counter #(.LO(8'h00)) i_min (
    .cur (r_min), .top (8'h59), .step (sec_c),
    .nxt (min_nxt), .carry (min_c));

  bcdcal_hour_step i_hour (
    .cur (r_hour), .step (min_c),
    .nxt (hour_nxt), .carry (day_c));

  bcdcal_wrap_counter #(.LO(8'h01)) i_dow (
    .cur (r_dow), .top (8'h07), .step (day_c),
    .nxt (dow_nxt), .carry (dow_c));

  bcdcal_month_len i_mlen (
    .mon (r_mon), .yr_tens_lsb (r_year[4]), .yr_ones (r_year[3:0]),
    .last_date (mlen), .leap (leap_yr));

  bcdcal_wrap_counter #(.LO(8'h01)) i_date (
    .cur (r_date), .top (mlen), .step (day_c),
    .nxt (date_nxt), .carry (date_c));

  bcdcal_wrap_counter #(.LO(8'h01)) i_mon (
    .cur (r_mon), .top (8'h12), .step (date_c),
    .nxt (mon_nxt), .carry (mon_c));

  bcdcal_wrap_counter #(.LO(8'h00)) i_year (
    .cur (r_year), .top (8'h99), .step (mon_c),
    .nxt (year_nxt), .carry (year_c));

  // Register bank: a write wins for its own register only
  always_ff @(posedge clk) begin
    if (rst) begin
      r_sec  <= 8'h80;
      r_min  <= 8'h00;
      r_hour <= 8'h00;
      r_dow  <= 8'h01;
      r_date <= 8'h01;
      r_mon  <= 8'h01;
      r_year <= 8'h00;
    end else begin
      r_sec  <= wr_hit[RG_SEC]  ? wr_val : (sec_nxt | {r_sec[7], 7'h00});
      r_min  <= wr_hit[RG_MIN]  ? wr_val : min_nxt;
      r_hour <= wr_hit[RG_HOUR] ? wr_val : hour_nxt;
      r_dow  <= wr_hit[RG_DOW]  ? wr_val : dow_nxt;
      r_date <= wr_hit[RG_DATE] ? wr_val : date_nxt;
      r_mon  <= wr_hit[RG_MON]  ? wr_val : mon_nxt;
      r_year <= wr_hit[RG_YEAR] ? wr_val : year_nxt;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        RG_SEC:  rd_data <= DW'(r_sec);
        RG_MIN:  rd_data <= DW'(r_min);
        RG_HOUR: rd_data <= DW'(r_hour);
        RG_DOW:  rd_data <= DW'(r_dow);
        RG_DATE: rd_data <= DW'(r_date);
        RG_MON:  rd_data <= DW'(r_mon);
        RG_YEAR: rd_data <= DW'(r_year);
        default: rd_data <= '0;
      endcase
    end
  end

  // Assertions
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (r_sec[7] && !wr_en) |=> ($stable(r_sec) && $stable(r_min) && $stable(r_hour)
      && $stable(r_dow) && $stable(r_date) && $stable(r_mon) && $stable(r_year))); // R2

  AST_SEC_MOVES: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en) |=> (r_sec[6:0] != $past(r_sec[6:0]))); // R3

  AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (min_c && !wr_en && r_hour[6] && r_hour[4:0] == 5'h11)
      |=> (r_hour[5] != $past(r_hour[5]) && r_hour[4:0] == 5'h12)); // R6

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (day_c && !wr_en && r_dow == 8'h07) |=> (r_dow == 8'h01)); // R7

  AST_DATE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (day_c && !wr_en && r_date >= mlen) |=> (r_date == 8'h01)); // R8

  AST_FEB_LEAP: assert property (@(posedge clk) disable iff (rst)
    (day_c && !wr_en && r_mon == 8'h02 && r_date == 8'h28 && leap_yr)
      |=> (r_date == 8'h29)); // R9

  AST_YEAR_CARRY: assert property (@(posedge clk) disable iff (rst)
    (mon_c && !wr_en) |=> (r_year != $past(r_year) && r_mon == 8'h01)); // R10

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (year_c && !wr_en) |=> (r_year == 8'h00)); // R10

  AST_DOW_CARRY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (dow_c) |-> day_c); // R7

endmodule

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  localparam int unsigned DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bcd_calendar_core #(.TICK_DIV(DIV)) i_bcd_calendar_core (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data));

  always #10 clk = ~clk;

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input [7:0] act, input [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input [2:0] a, input [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input [2:0] a, output [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // Release the stop flag with seconds s0, let exactly one step happen,
  // read the new seconds, then stop again.
  task automatic one_step(input [7:0] s0, output [7:0] s1);
    wr(3'd0, s0 & 8'h7F);
    repeat (DIV) @(posedge clk);
    rd(3'd0, s1);
    wr(3'd0, 8'h80);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd0, v); check("R1 seconds", v, 8'h80);
    rd(3'd1, v); check("R1 minutes", v, 8'h00);
    rd(3'd2, v); check("R1 hours",   v, 8'h00);
    rd(3'd3, v); check("R1 day",     v, 8'h01);
    rd(3'd4, v); check("R1 date",    v, 8'h01);
    rd(3'd5, v); check("R1 month",   v, 8'h01);
    rd(3'd6, v); check("R1 year",    v, 8'h00);
  endtask

  task automatic t_halt;
    logic [7:0] v;
    repeat (5 * DIV) @(posedge clk);
    rd(3'd0, v); check("R2 stopped seconds", v, 8'h80);
    wr(3'd1, 8'h59);
    wr(3'd0, 8'hD9);
    repeat (5 * DIV) @(posedge clk);
    rd(3'd0, v); check("R2 stopped seconds 59", v, 8'hD9);
    rd(3'd1, v); check("R2 stopped minutes", v, 8'h59);
  endtask

  task automatic t_phase;
    logic [7:0] v;
    wr(3'd0, 8'h10);
    repeat (DIV - 1) @(posedge clk);
    rd(3'd0, v); check("R3 before first step", v, 8'h10);
    rd(3'd0, v); check("R3 first step", v, 8'h11);
    repeat (DIV - 1) @(posedge clk);
    rd(3'd0, v); check("R3 second step", v, 8'h12);
    wr(3'd0, 8'h80);
  endtask

  task automatic t_bcd_digit;
    logic [7:0] v;
    wr(3'd1, 8'h09);
    one_step(8'h09, v); check("R4 seconds 09->10", v, 8'h10);
    rd(3'd1, v); check("R4 minutes unchanged", v, 8'h09);
    one_step(8'h59, v); check("R4 seconds wrap", v, 8'h00);
    rd(3'd1, v); check("R4 minutes 09->10", v, 8'h10);
  endtask

  task automatic t_full_roll;
    logic [7:0] v;
    wr(3'd1, 8'h59); wr(3'd2, 8'h23); wr(3'd3, 8'h07);
    wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
    one_step(8'h59, v); check("R4 seconds wrap", v, 8'h00);
    rd(3'd1, v); check("R4 minutes wrap", v, 8'h00);
    rd(3'd2, v); check("R5 hour 23->00", v, 8'h00);
    rd(3'd3, v); check("R7 day 7->1", v, 8'h01);
    rd(3'd4, v); check("R8 Dec 31 wrap", v, 8'h01);
    rd(3'd5, v); check("R10 month 12->01", v, 8'h01);
    rd(3'd6, v); check("R10 year 99->00", v, 8'h00);
  endtask

  task automatic t_hour24;
    logic [7:0] v;
    wr(3'd1, 8'h59); wr(3'd2, 8'h19); wr(3'd3, 8'h02); wr(3'd4, 8'h05);
    one_step(8'h59, v);
    rd(3'd2, v); check("R5 hour 19->20", v, 8'h20);
    rd(3'd3, v); check("R5 no day carry", v, 8'h02);
    rd(3'd4, v); check("R5 no date carry", v, 8'h05);
  endtask

  task automatic t_hour12;
    logic [7:0] v;
    wr(3'd3, 8'h03); wr(3'd4, 8'h10); wr(3'd5, 8'h01);
    wr(3'd1, 8'h59); wr(3'd2, 8'h51);
    one_step(8'h59, v);
    rd(3'd2, v); check("R6 11 AM -> 12 PM", v, 8'h72);
    rd(3'd3, v); check("R6 no day at noon", v, 8'h03);
    wr(3'd1, 8'h59);
    one_step(8'h59, v);
    rd(3'd2, v); check("R6 12 PM -> 1 PM", v, 8'h61);
    wr(3'd1, 8'h59); wr(3'd2, 8'h71);
    one_step(8'h59, v);
    rd(3'd2, v); check("R6 11 PM -> 12 AM", v, 8'h52);
    rd(3'd3, v); check("R7 day 3->4", v, 8'h04);
    rd(3'd4, v); check("R6 date advances at midnight", v, 8'h11);
    wr(3'd1, 8'h59); wr(3'd2, 8'h49);
    one_step(8'h59, v);
    rd(3'd2, v); check("R6 9 AM -> 10 AM", v, 8'h50);
  endtask

  task automatic roll_day(input string req, input [7:0] yr, input [7:0] mo,
                          input [7:0] dt, input [7:0] exp_dt, input [7:0] exp_mo);
    logic [7:0] v;
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59);
    one_step(8'h59, v);
    rd(3'd4, v); check({req, " date"}, v, exp_dt);
    rd(3'd5, v); check({req, " month"}, v, exp_mo);
    rd(3'd6, v); check({req, " year"}, v, yr);
  endtask

  task automatic t_months;
    roll_day("R8 Apr 30",          8'h12, 8'h04, 8'h30, 8'h01, 8'h05);
    roll_day("R8 Nov 30",          8'h12, 8'h11, 8'h30, 8'h01, 8'h12);
    roll_day("R8 Jan 30",          8'h12, 8'h01, 8'h30, 8'h31, 8'h01);
    roll_day("R8 Jan 31",          8'h12, 8'h01, 8'h31, 8'h01, 8'h02);
    roll_day("R9 Feb 28 year 23",  8'h23, 8'h02, 8'h28, 8'h01, 8'h03);
    roll_day("R9 Feb 28 year 24",  8'h24, 8'h02, 8'h28, 8'h29, 8'h02);
    roll_day("R9 Feb 29 year 24",  8'h24, 8'h02, 8'h29, 8'h01, 8'h03);
    roll_day("R9 Feb 28 year 00",  8'h00, 8'h02, 8'h28, 8'h29, 8'h02);
    roll_day("R9 Feb 28 year 18",  8'h18, 8'h02, 8'h28, 8'h01, 8'h03);
  endtask

  task automatic t_year_digit;
    logic [7:0] v;
    wr(3'd6, 8'h19); wr(3'd5, 8'h12); wr(3'd4, 8'h31);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59);
    one_step(8'h59, v);
    rd(3'd6, v); check("R10 year 19->20", v, 8'h20);
    rd(3'd5, v); check("R10 month wraps to 01", v, 8'h01);
  endtask

  task automatic t_writes;
    logic [7:0] v;
    wr(3'd1, 8'hC2); wr(3'd2, 8'h92); wr(3'd3, 8'hF3);
    wr(3'd4, 8'hD7); wr(3'd5, 8'hE5); wr(3'd6, 8'h42);
    wr(3'd7, 8'hAA);
    rd(3'd1, v); check("R11 minutes mask", v, 8'h42);
    rd(3'd2, v); check("R11 hours mask", v, 8'h12);
    rd(3'd3, v); check("R11 day mask", v, 8'h03);
    rd(3'd4, v); check("R11 date mask", v, 8'h17);
    rd(3'd5, v); check("R11 month mask", v, 8'h05);
    rd(3'd6, v); check("R11 year", v, 8'h42);
    rd(3'd7, v); check("R11 address 7 reads 0", v, 8'h00);
    rd(3'd0, v); check("R11 address 7 write ignored (seconds)", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_halt();
    t_phase();
    t_bcd_digit();
    t_full_roll();
    t_hour24();
    t_hour12();
    t_months();
    t_year_digit();
    t_writes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule